// File: doc/BRIEF.md
# Half-Bridge Short-Circuit Monitor

This block watches a set of half-bridge phases and reports when a phase's output is not where its gate commands put it. Each phase has two command bits, one for the upper switch and one for the lower switch. The pair decodes to a driven-high, a driven-low or a floating state. Each phase also returns one digitized level bit taken from its output node. When a driven phase reads back the wrong level, the block raises a registered short-circuit flag. A floating phase is never checked.

Every switching edge produces a short, expected disagreement while the output slews. To hide it, each phase has its own blanking counter. Any change in that phase's command pair restarts the counter, and mismatches on that phase are ignored until it runs out. The flag is only a report and never turns the bridge off by itself.

An optional fault latch, chosen by a parameter, turns either the short-circuit flag or an over-temperature input into a global disable line. The line stays high until a clear input is asserted. If a set source and the clear arrive in the same cycle, the set wins.

Top module: `sc_monitor`

## Requirements
- R1: Per phase, command pair {upper,lower} = 10 means driven high (expected level 1), 01 means driven low (expected level 0), and 00 or 11 means floating, which never counts as a mismatch.
- R2: A mismatch on a driven phase outside its blanking window, sampled at a clock edge, makes `sc_flag` high right after that edge.
- R3: A change in a phase's command pair blanks that phase at the edge where the change is first seen and for the next `BLANK_CYC` edges. Mismatches on that phase in this window do not set `sc_flag`.
- R4: Blanking is per phase. A window running on one phase does not hide a mismatch on another phase.
- R5: `sc_flag` is registered. It goes low after the first edge at which no unblanked mismatch is present.
- R6: With the latch enabled, `fault_dis` goes high after any edge at which `sc_flag` or `ot_in` is high.
- R7: `fault_dis` holds its value until an edge at which `flt_clr` is high and no set source is present. That edge clears it.
- R8: When a set source and `flt_clr` are both present at an edge, `fault_dis` is high after that edge.
- R9: Asynchronous active-low reset clears `sc_flag`, `fault_dis` and all blanking state.
- R10: With `LATCH_EN` = 0, `fault_dis` stays low whatever the flags do, and `sc_flag` behaves as with the latch enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_hi | input | NPH | Upper-switch command per phase |
| cmd_lo | input | NPH | Lower-switch command per phase |
| out_obs | input | NPH | Digitized observed output level per phase |
| ot_in | input | 1 | Over-temperature flag |
| flt_clr | input | 1 | Fault latch clear |
| sc_flag | output | 1 | Registered short-circuit flag |
| fault_dis | output | 1 | Latched global disable |

## Verification
The case that is hardest to reach from the ports is a mismatch on one phase that is still blanked while another phase is clean. Close behind it is the exact last edge of a window. The stimulus changes a phase's command while its readback is left wrong on purpose. It then holds every input steady, so the flag has to appear on exactly the edge after the window ends. A second sequence restarts blanking on one phase while the other phase is already faulty, so the flag must persist.

// File: rtl/sc_monitor.sv
module sc_monitor #(
  parameter int NPH       = 2,
  parameter int BLANK_CYC = 50,
  parameter bit LATCH_EN  = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NPH-1:0] cmd_hi,
  input  logic [NPH-1:0] cmd_lo,
  input  logic [NPH-1:0] out_obs,
  input  logic           ot_in,
  input  logic           flt_clr,
  output logic           sc_flag,
  output logic           fault_dis
);
  localparam int CW = $clog2(BLANK_CYC + 1);

  logic [NPH-1:0] hi_q, lo_q, chg, blank, drv, mis;
  logic [CW-1:0]  cnt [NPH];
  logic           sc_q, flt_q;

  assign chg = (cmd_hi ^ hi_q) | (cmd_lo ^ lo_q);
  assign drv = cmd_hi ^ cmd_lo;
  assign mis = drv & (out_obs ^ cmd_hi);

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    assign blank[p] = chg[p] || (cnt[p] != '0);
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                cnt[p] <= '0;
      else if (chg[p])           cnt[p] <= CW'(BLANK_CYC);
      else if (cnt[p] != '0)     cnt[p] <= cnt[p] - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
      sc_q <= 1'b0;
    end else begin
      hi_q <= cmd_hi;
      lo_q <= cmd_lo;
      sc_q <= |(mis & ~blank);
    end

  assign sc_flag = sc_q;

  if (LATCH_EN) begin : g_latch
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)               flt_q <= 1'b0;
      else if (sc_q || ot_in)   flt_q <= 1'b1;
      else if (flt_clr)         flt_q <= 1'b0;
  end else begin : g_nolatch
    assign flt_q = 1'b0;
  end

  assign fault_dis = flt_q;

  assert_rise_needs_unblanked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sc_flag) |-> $past(|(mis & ~blank)));

  assert_change_blanks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|chg) |=> (|blank));

  assert_floating_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (drv == '0) |=> !sc_flag);

  assert_latch_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (LATCH_EN && (sc_flag || ot_in)) |=> fault_dis);

  assert_latch_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_dis && !flt_clr) |=> fault_dis);

  assert_dis_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_dis) |-> $past(sc_flag || ot_in));
endmodule

// File: tb/sc_monitor_bench.sv
module sc_monitor_bench;
  localparam int NPH = 2;
  localparam int BLK = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NPH-1:0] cmd_hi = '0, cmd_lo = '0, out_obs = '0;
  logic ot_in = 1'b0, flt_clr = 1'b0;
  logic sc_flag, fault_dis, sc2, dis2;

  always #2 clk = ~clk;

  sc_monitor #(.NPH(NPH), .BLANK_CYC(BLK), .LATCH_EN(1'b1)) u_sc_monitor (
    .clk(clk), .rst_n(rst_n), .cmd_hi(cmd_hi), .cmd_lo(cmd_lo), .out_obs(out_obs),
    .ot_in(ot_in), .flt_clr(flt_clr), .sc_flag(sc_flag), .fault_dis(fault_dis));

  sc_monitor #(.NPH(NPH), .BLANK_CYC(BLK), .LATCH_EN(1'b0)) u_sc_monitor_nolatch (
    .clk(clk), .rst_n(rst_n), .cmd_hi(cmd_hi), .cmd_lo(cmd_lo), .out_obs(out_obs),
    .ot_in(ot_in), .flt_clr(flt_clr), .sc_flag(sc2), .fault_dis(dis2));

  typedef struct { logic sc; logic dis; string tag; } exp_t;
  exp_t q[$];

  int tests = 0, fails = 0;
  bit done = 1'b0;

  logic [NPH-1:0] m_hi = '0, m_lo = '0;
  int m_cnt [NPH];
  logic m_sc = 1'b0, m_dis = 1'b0;

  task automatic check(input string tag, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic [NPH-1:0] hi, input logic [NPH-1:0] lo,
                      input logic [NPH-1:0] lvl, input logic ot, input logic clr,
                      input string tag);
    logic nsc;
    logic ndis;
    exp_t e;
    @(negedge clk);
    cmd_hi = hi; cmd_lo = lo; out_obs = lvl; ot_in = ot; flt_clr = clr;
    nsc = 1'b0;
    for (int p = 0; p < NPH; p++) begin
      logic ch, bl, mi;
      ch = (hi[p] != m_hi[p]) || (lo[p] != m_lo[p]);
      bl = ch || (m_cnt[p] != 0);
      mi = (hi[p] != lo[p]) && (lvl[p] != hi[p]);
      if (mi && !bl) nsc = 1'b1;
      if (ch) m_cnt[p] = BLK;
      else if (m_cnt[p] != 0) m_cnt[p]--;
    end
    ndis = (m_sc || ot) ? 1'b1 : (clr ? 1'b0 : m_dis);
    m_hi = hi; m_lo = lo; m_sc = nsc; m_dis = ndis;
    e.sc = nsc; e.dis = ndis; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic hold(input int n, input logic [NPH-1:0] hi, input logic [NPH-1:0] lo,
                      input logic [NPH-1:0] lvl, input string tag);
    for (int i = 0; i < n; i++) step(hi, lo, lvl, 1'b0, 1'b0, tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() != 0) begin
      exp_t e;
      e = q.pop_front();
      check({e.tag, " sc_flag"}, sc_flag, e.sc);
      check({e.tag, " fault_dis"}, fault_dis, e.dis);
      check("R10 no-latch sc_flag", sc2, e.sc);
      check("R10 no-latch fault_dis", dis2, 1'b0);
    end
  end

  initial begin
    for (int p = 0; p < NPH; p++) m_cnt[p] = 0;
    repeat (3) @(negedge clk);
    check("R9 reset sc_flag", sc_flag, 1'b0);
    check("R9 reset fault_dis", fault_dis, 1'b0);
    rst_n = 1'b1;
    // phase0 high, phase1 low, correct readback
    hold(60, 2'b01, 2'b10, 2'b01, "R1 R3 startup");
    // phase0 reads low while driven high
    hold(3, 2'b01, 2'b10, 2'b00, "R2 R6 mismatch");
    // clear while fault persists
    step(2'b01, 2'b10, 2'b00, 1'b0, 1'b1, "R8 set wins");
    hold(2, 2'b01, 2'b10, 2'b01, "R5 mismatch removed");
    step(2'b01, 2'b10, 2'b01, 1'b0, 1'b1, "R7 clear");
    hold(2, 2'b01, 2'b10, 2'b01, "R7 cleared stays");
    // phase0 to low, readback still high: blanked then flagged
    hold(56, 2'b00, 2'b11, 2'b01, "R3 window end");
    step(2'b00, 2'b11, 2'b00, 1'b0, 1'b1, "R7 clear after sc");
    hold(2, 2'b00, 2'b11, 2'b00, "R7 idle");
    // floating and both-on states with odd readback
    hold(60, 2'b00, 2'b00, 2'b11, "R1 floating");
    hold(60, 2'b11, 2'b11, 2'b00, "R1 both on");
    // phase0 high correct, phase1 low wrong after window
    hold(55, 2'b01, 2'b10, 2'b11, "R3 R4 setup");
    // restart blanking on phase0 only; phase1 mismatch must remain visible
    hold(1, 2'b00, 2'b10, 2'b10, "R4 other phase");
    hold(5, 2'b00, 2'b10, 2'b10, "R4 other phase");
    hold(55, 2'b01, 2'b10, 2'b01, "R5 fixed");
    step(2'b01, 2'b10, 2'b01, 1'b0, 1'b1, "R7 clear");
    // over-temperature path
    step(2'b01, 2'b10, 2'b01, 1'b1, 1'b0, "R6 ot");
    hold(3, 2'b01, 2'b10, 2'b01, "R7 ot hold");
    step(2'b01, 2'b10, 2'b01, 1'b1, 1'b1, "R8 ot vs clr");
    step(2'b01, 2'b10, 2'b01, 1'b0, 1'b1, "R7 ot clear");
    hold(2, 2'b01, 2'b10, 2'b01, "R7 ot idle");
    // reset mid-fault
    hold(2, 2'b01, 2'b10, 2'b00, "R2 prefault");
    @(negedge clk);
    while (q.size() != 0) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R9 async reset sc_flag", sc_flag, 1'b0);
    check("R9 async reset fault_dis", fault_dis, 1'b0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule